// File: doc/BRIEF.md
# Staged Pipeline Control and Write-Register Carrier

This block is the control half of a five-stage, in-order, 32-bit load/store processor. The decode stage gives it the current instruction word and the address of the next sequential instruction. It looks at the opcode once, in decode, and turns it into control bits. These bits fall into three groups, one for execute, one for memory access and one for write-back. Each group rides in the stage registers with its instruction, and a register keeps a group only while some later stage still needs it.

The block carries both candidate destination fields into execute and picks one there. The chosen number then travels with its instruction to write-back, so a write always targets the instruction that produced it. The block also sign-extends the immediate and forms the branch target from the branching instruction's own next-sequential address. In the memory stage it decides whether the program counter takes that target. The surrounding datapath supplies the ALU zero flag during execute and consumes the staged signals. The register file, ALU, memories, hazard detection and forwarding are outside this block.

Top module: `pipe_ctrl_stager`

## Requirements
- R1: An instruction whose bits 31:26 are 000000 (register form) produces the following. In execute: ALU operation code 2'b10, ALU second operand from the register, and destination number from bits 15:11. In write-back: write enable 1 with the load-result select at 0.
- R2: Opcode 100011 (load) produces the following. In execute: ALU operand select 1, operation code 2'b00 and destination number from bits 20:16. In memory: read 1 and write 0. In write-back: write enable 1 and load-result select 1.
- R3: Opcode 101011 (store) produces the following. In execute: ALU operand select 1 and operation code 2'b00. In memory: write 1 and read 0. In write-back: write enable 0.
- R4: Opcode 000100 (branch-if-equal) produces operation code 2'b01 in execute. It causes no memory access and no register write.
- R5: In the memory stage, the PC-source output is 1 exactly when the staged branch bit is 1 and the zero flag sampled in that instruction's execute cycle was 1.
- R6: The branch target shown in the memory stage equals the instruction's own decode-stage next address plus its sign-extended bits 15:0 shifted left by two, modulo 2^32.
- R7: Any other opcode produces all-zero control in every stage.
- R8: Timing is counted in rising clock edges after the instruction stands at decode. Execute outputs show the instruction after one edge, memory outputs after two, and write-back outputs after three. Back-to-back instructions of different kinds each report their own destination number and enable.
- R9: The execute-stage immediate output is bits 15:0 of the instruction, sign-extended to 32 bits.
- R10: A synchronous active-high reset clears every staged control bit. After reset, all enables and selects read 0. An instruction that is in flight when reset is sampled never raises the write-back enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_instr | input | 32 | Instruction word in the decode stage |
| id_pc4 | input | 32 | Next sequential address of the decode-stage instruction |
| ex_zero | input | 1 | ALU zero flag of the instruction in execute |
| ex_alu_src | output | 1 | ALU second operand select (1 = immediate) |
| ex_alu_op | output | 2 | ALU operation class for the ALU control |
| ex_imm | output | 32 | Sign-extended immediate of the execute instruction |
| ex_dest | output | 5 | Chosen destination register number in execute |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| mem_pc_src | output | 1 | Take the branch target |
| mem_br_target | output | 32 | Branch target of the memory-stage instruction |
| wb_reg_write | output | 1 | Register file write enable |
| wb_mem_to_reg | output | 1 | Write data select (1 = loaded data) |
| wb_dest | output | 5 | Register number written in write-back |

## Verification
Each instruction kind is first sent alone between bubbles, so every stage output can be tied to a single decode. A dense back-to-back stream of register-form, load, store and branch words comes next, with distinct destination fields. That stream exposes any stage that takes its destination or enable from the wrong instruction. Branches are sent with the zero flag both set and clear, and with positive and negative offsets, which separates the taken and not-taken cases and checks the sign extension in the target. Unknown opcodes and a reset in mid-flight show that no stray enables survive.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int XLEN     = 32;
    localparam int RIDX     = 5;
    localparam int OPW      = 6;
    localparam int IMMW     = 16;
    localparam int OP_HI    = 31;
    localparam int RT_HI    = 20;
    localparam int RD_HI    = 15;
    localparam int BR_SHIFT = 2;

    localparam logic [OPW-1:0] OP_REG   = 6'b000000;
    localparam logic [OPW-1:0] OP_LOAD  = 6'b100011;
    localparam logic [OPW-1:0] OP_STORE = 6'b101011;
    localparam logic [OPW-1:0] OP_BEQ   = 6'b000100;

    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_FUNC = 2'b10,
        ALU_RSV  = 2'b11
    } alu_cls_e;

    typedef struct packed {
        logic     use_imm;
        alu_cls_e alu_cls;
        logic     pick_rd;
    } ex_grp_t;

    typedef struct packed {
        logic rd_en;
        logic wr_en;
        logic is_br;
    } mem_grp_t;

    typedef struct packed {
        logic wr_reg;
        logic from_mem;
    } wb_grp_t;

    typedef struct packed {
        ex_grp_t  ex;
        mem_grp_t mem;
        wb_grp_t  wb;
    } ctl_t;

    typedef struct packed {
        ctl_t             ctl;
        logic [RIDX-1:0]  rt;
        logic [RIDX-1:0]  rd;
        logic [XLEN-1:0]  pc4;
        logic [XLEN-1:0]  imm;
    } idex_t;

    typedef struct packed {
        mem_grp_t         mem;
        wb_grp_t          wb;
        logic             zero;
        logic [RIDX-1:0]  dest;
        logic [XLEN-1:0]  target;
    } exmem_t;

    typedef struct packed {
        wb_grp_t          wb;
        logic [RIDX-1:0]  dest;
    } memwb_t;

    function automatic ctl_t decode_op(input logic [OPW-1:0] op);
        ctl_t c;
        c = '0;
        c.ex.alu_cls = ALU_ADD;
        unique case (op)
            OP_REG: begin
                c.ex.pick_rd = 1'b1;
                c.ex.alu_cls = ALU_FUNC;
                c.wb.wr_reg  = 1'b1;
            end
            OP_LOAD: begin
                c.ex.use_imm  = 1'b1;
                c.mem.rd_en   = 1'b1;
                c.wb.from_mem = 1'b1;
                c.wb.wr_reg   = 1'b1;
            end
            OP_STORE: begin
                c.ex.use_imm = 1'b1;
                c.mem.wr_en  = 1'b1;
            end
            OP_BEQ: begin
                c.mem.is_br  = 1'b1;
                c.ex.alu_cls = ALU_SUB;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

    function automatic logic [XLEN-1:0] sext_imm(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
    import ctl_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    input  logic [XLEN-1:0] pc4,
    output idex_t           pkt
);
    localparam int OP_LO = OP_HI - OPW + 1;
    localparam int RT_LO = RT_HI - RIDX + 1;
    localparam int RD_LO = RD_HI - RIDX + 1;

    always_comb begin
        pkt     = '0;
        pkt.ctl = decode_op(instr[OP_HI:OP_LO]);
        pkt.rt  = instr[RT_HI:RT_LO];
        pkt.rd  = instr[RD_HI:RD_LO];
        pkt.pc4 = pc4;
        pkt.imm = sext_imm(instr[IMMW-1:0]);
    end
endmodule

// File: rtl/stage_reg.sv
module stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/ex_stage.sv
module ex_stage
    import ctl_pkg::*;
(
    input  idex_t           cur,
    input  logic            zero,
    output logic [RIDX-1:0] dest,
    output exmem_t          nxt
);
    logic [XLEN-1:0] offs;

    assign dest = cur.ctl.ex.pick_rd ? cur.rd : cur.rt;
    assign offs = cur.imm << BR_SHIFT;

    always_comb begin
        nxt        = '0;
        nxt.mem    = cur.ctl.mem;
        nxt.wb     = cur.ctl.wb;
        nxt.zero   = zero;
        nxt.dest   = dest;
        nxt.target = cur.pc4 + offs;
    end
endmodule

// File: rtl/mem_stage.sv
module mem_stage
    import ctl_pkg::*;
(
    input  exmem_t cur,
    output logic   take_br,
    output memwb_t nxt
);
    assign take_br = cur.mem.is_br & cur.zero;

    always_comb begin
        nxt      = '0;
        nxt.wb   = cur.wb;
        nxt.dest = cur.dest;
    end
endmodule

// File: rtl/pipe_ctrl_stager.sv
module pipe_ctrl_stager
    import ctl_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [XLEN-1:0] id_instr,
    input  logic [XLEN-1:0] id_pc4,
    input  logic            ex_zero,
    output logic            ex_alu_src,
    output logic [1:0]      ex_alu_op,
    output logic [XLEN-1:0] ex_imm,
    output logic [RIDX-1:0] ex_dest,
    output logic            mem_read,
    output logic            mem_write,
    output logic            mem_pc_src,
    output logic [XLEN-1:0] mem_br_target,
    output logic            wb_reg_write,
    output logic            wb_mem_to_reg,
    output logic [RIDX-1:0] wb_dest
);
    localparam int W_IDEX  = $bits(idex_t);
    localparam int W_EXMEM = $bits(exmem_t);
    localparam int W_MEMWB = $bits(memwb_t);
    localparam int RS_HI   = OP_HI - OPW;
    localparam int RS_LO   = RS_HI - RIDX + 1;

    logic   unused_rs;
    idex_t  id_pkt, idex_q;
    exmem_t ex_pkt, exmem_q;
    memwb_t mem_pkt, memwb_q;

    assign unused_rs = ^id_instr[RS_HI:RS_LO];

    ctl_decode u_dec (
        .instr (id_instr),
        .pc4   (id_pc4),
        .pkt   (id_pkt)
    );

    stage_reg #(.W(W_IDEX)) u_idex (
        .clk (clk), .rst (rst), .d (id_pkt), .q (idex_q)
    );

    ex_stage u_ex (
        .cur  (idex_q),
        .zero (ex_zero),
        .dest (ex_dest),
        .nxt  (ex_pkt)
    );

    stage_reg #(.W(W_EXMEM)) u_exmem (
        .clk (clk), .rst (rst), .d (ex_pkt), .q (exmem_q)
    );

    mem_stage u_mem (
        .cur     (exmem_q),
        .take_br (mem_pc_src),
        .nxt     (mem_pkt)
    );

    stage_reg #(.W(W_MEMWB)) u_memwb (
        .clk (clk), .rst (rst), .d (mem_pkt), .q (memwb_q)
    );

    assign ex_alu_src    = idex_q.ctl.ex.use_imm;
    assign ex_alu_op     = idex_q.ctl.ex.alu_cls;
    assign ex_imm        = idex_q.imm;
    assign mem_read      = exmem_q.mem.rd_en;
    assign mem_write     = exmem_q.mem.wr_en;
    assign mem_br_target = exmem_q.target;
    assign wb_reg_write  = memwb_q.wb.wr_reg;
    assign wb_mem_to_reg = memwb_q.wb.from_mem;
    assign wb_dest       = memwb_q.dest;
endmodule

// File: rtl/pipe_ctrl_stager_chk.sv
module pipe_ctrl_stager_chk
    import ctl_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] id_instr,
    input logic [XLEN-1:0] id_pc4,
    input logic            ex_zero,
    input logic            ex_alu_src,
    input logic [1:0]      ex_alu_op,
    input logic [XLEN-1:0] ex_imm,
    input logic [RIDX-1:0] ex_dest,
    input logic            mem_read,
    input logic            mem_write,
    input logic            mem_pc_src,
    input logic [XLEN-1:0] mem_br_target,
    input logic            wb_reg_write,
    input logic            wb_mem_to_reg,
    input logic [RIDX-1:0] wb_dest
);
    p_reset_clears_r10: assert property (@(posedge clk)
        rst |=> (!wb_reg_write && !wb_mem_to_reg && !mem_read &&
                 !mem_write && !mem_pc_src && !ex_alu_src && ex_alu_op == 2'b00));

    p_load_select_r2: assert property (@(posedge clk) disable iff (rst)
        wb_mem_to_reg |-> ($past(mem_read) && wb_reg_write));

    p_store_no_write_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_write && !$past(rst)) |=> !wb_reg_write);

    p_branch_no_mem_r4: assert property (@(posedge clk) disable iff (rst)
        mem_pc_src |-> (!mem_read && !mem_write));

    p_own_dest_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_reg_write && !$past(rst) && !$past(rst, 2)) |-> wb_dest == $past(ex_dest, 2));

    p_mem_excl_r7: assert property (@(posedge clk) disable iff (rst)
        !(mem_read && mem_write));
endmodule

bind pipe_ctrl_stager pipe_ctrl_stager_chk u_chk (.*);

// File: tb/sim_pipe_ctrl_stager.sv
module sim_pipe_ctrl_stager;
    localparam int PERIOD = 10;
    localparam int MAXN   = 16;
    localparam logic [31:0] BUBBLE = 32'hFC00_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] id_instr = BUBBLE;
    logic [31:0] id_pc4 = '0;
    logic        ex_zero = 1'b0;
    logic        ex_alu_src, mem_read, mem_write, mem_pc_src;
    logic        wb_reg_write, wb_mem_to_reg;
    logic [1:0]  ex_alu_op;
    logic [31:0] ex_imm, mem_br_target;
    logic [4:0]  ex_dest, wb_dest;

    int checks = 0;
    int errors = 0;

    logic [31:0] s_ins [MAXN];
    logic [31:0] s_pc4 [MAXN];
    logic        s_z   [MAXN];
    int          s_n = 0;

    always #(PERIOD/2) clk = ~clk;

    pipe_ctrl_stager u0 (
        .clk, .rst, .id_instr, .id_pc4, .ex_zero,
        .ex_alu_src, .ex_alu_op, .ex_imm, .ex_dest,
        .mem_read, .mem_write, .mem_pc_src, .mem_br_target,
        .wb_reg_write, .wb_mem_to_reg, .wb_dest
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_r(input int rs, input int rt, input int rd);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 11'h020};
    endfunction

    function automatic logic [31:0] mk_i(input logic [5:0] op, input int rs,
                                         input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    function automatic string req_of(input logic [5:0] op);
        case (op)
            6'b000000: return "R1";
            6'b100011: return "R2";
            6'b101011: return "R3";
            6'b000100: return "R4";
            default:   return "R7";
        endcase
    endfunction

    // expectations derived from the requirement text
    task automatic check_ex(input int i);
        logic [5:0]  op;
        logic [31:0] w;
        logic        isr, isl, iss, isb;
        w = s_ins[i]; op = w[31:26];
        isr = (op == 6'b000000); isl = (op == 6'b100011);
        iss = (op == 6'b101011); isb = (op == 6'b000100);
        chk(req_of(op), "ex_alu_src", {31'd0, ex_alu_src}, {31'd0, isl | iss});
        chk(req_of(op), "ex_alu_op", {30'd0, ex_alu_op},
            isr ? 32'd2 : (isb ? 32'd1 : 32'd0));
        chk("R9", "ex_imm", ex_imm, {{16{w[15]}}, w[15:0]});
        if (isr || isl)
            chk("R8", "ex_dest", {27'd0, ex_dest},
                {27'd0, isr ? w[15:11] : w[20:16]});
    endtask

    task automatic check_mem(input int i);
        logic [5:0]  op;
        logic [31:0] w, tgt;
        logic        isb;
        w = s_ins[i]; op = w[31:26];
        isb = (op == 6'b000100);
        chk(req_of(op), "mem_read", {31'd0, mem_read}, {31'd0, op == 6'b100011});
        chk(req_of(op), "mem_write", {31'd0, mem_write}, {31'd0, op == 6'b101011});
        chk("R5", "mem_pc_src", {31'd0, mem_pc_src}, {31'd0, isb & s_z[i]});
        if (isb) begin
            tgt = s_pc4[i] + ({{16{w[15]}}, w[15:0]} << 2);
            chk("R6", "mem_br_target", mem_br_target, tgt);
        end
    endtask

    task automatic check_wb(input int i);
        logic [5:0]  op;
        logic [31:0] w;
        logic        isr, isl;
        w = s_ins[i]; op = w[31:26];
        isr = (op == 6'b000000); isl = (op == 6'b100011);
        chk("R8", "wb_reg_write", {31'd0, wb_reg_write}, {31'd0, isr | isl});
        chk(req_of(op), "wb_mem_to_reg", {31'd0, wb_mem_to_reg}, {31'd0, isl});
        if (isr || isl)
            chk("R8", "wb_dest", {27'd0, wb_dest},
                {27'd0, isr ? w[15:11] : w[20:16]});
    endtask

    // called at a falling edge; each loop step checks then drives
    task automatic run_seq();
        for (int c = 0; c < s_n + 3; c++) begin
            if (c >= 1 && c - 1 < s_n) check_ex(c - 1);
            if (c >= 2 && c - 2 < s_n) check_mem(c - 2);
            if (c >= 3)                check_wb(c - 3);
            id_instr = (c < s_n) ? s_ins[c] : BUBBLE;
            id_pc4   = (c < s_n) ? s_pc4[c] : 32'd0;
            ex_zero  = (c >= 1 && c - 1 < s_n) ? s_z[c - 1] : 1'b0;
            @(negedge clk);
        end
        ex_zero = 1'b0;
    endtask

    task automatic add(input logic [31:0] w, input logic [31:0] pc, input logic z);
        s_ins[s_n] = w; s_pc4[s_n] = pc; s_z[s_n] = z; s_n++;
    endtask

    task automatic t_reset();
        rst = 1'b1; id_instr = mk_r(1, 2, 3);
        @(negedge clk); @(negedge clk);
        chk("R10", "wb_reg_write", {31'd0, wb_reg_write}, 32'd0);
        chk("R10", "mem_read", {31'd0, mem_read}, 32'd0);
        chk("R10", "mem_write", {31'd0, mem_write}, 32'd0);
        chk("R10", "mem_pc_src", {31'd0, mem_pc_src}, 32'd0);
        chk("R10", "ex_alu_op", {30'd0, ex_alu_op}, 32'd0);
        rst = 1'b0; id_instr = BUBBLE;
        @(negedge clk); @(negedge clk); @(negedge clk);
    endtask

    task automatic t_single_kinds();
        s_n = 0; add(mk_r(1, 2, 9), 32'h100, 1'b0); run_seq();
        s_n = 0; add(mk_i(6'b100011, 3, 12, 16'h0010), 32'h104, 1'b0); run_seq();
        s_n = 0; add(mk_i(6'b101011, 3, 13, 16'hFFF8), 32'h108, 1'b0); run_seq();
        s_n = 0; add(mk_i(6'b000100, 4, 5, 16'h0007), 32'h10C, 1'b1); run_seq();
    endtask

    task automatic t_branches();
        s_n = 0;
        add(mk_i(6'b000100, 1, 2, 16'hFFFC), 32'h0000_2000, 1'b1);
        add(mk_i(6'b000100, 1, 2, 16'h0003), 32'h0000_2004, 1'b0);
        add(mk_i(6'b000100, 1, 2, 16'h8000), 32'h0004_0000, 1'b1);
        add(mk_i(6'b000100, 1, 2, 16'h7FFF), 32'hFFFF_FFF0, 1'b0);
        run_seq();
    endtask

    task automatic t_unknown();
        s_n = 0;
        add(mk_i(6'b001000, 1, 17, 16'h1234), 32'h40, 1'b1);
        add(32'hFFFF_FFFF, 32'h44, 1'b1);
        add(mk_i(6'b100000, 2, 18, 16'h0001), 32'h48, 1'b0);
        run_seq();
    endtask

    task automatic t_stream();
        s_n = 0;
        add(mk_r(1, 2, 21), 32'h200, 1'b0);
        add(mk_i(6'b100011, 4, 22, 16'h0040), 32'h204, 1'b0);
        add(mk_i(6'b101011, 5, 23, 16'h0044), 32'h208, 1'b1);
        add(mk_i(6'b000100, 6, 24, 16'hFFF0), 32'h20C, 1'b1);
        add(mk_r(7, 8, 25), 32'h210, 1'b1);
        add(mk_r(9, 10, 26), 32'h214, 1'b0);
        add(mk_i(6'b100011, 11, 27, 16'h8004), 32'h218, 1'b0);
        add(mk_i(6'b100011, 12, 28, 16'h0008), 32'h21C, 1'b0);
        add(mk_i(6'b000100, 13, 29, 16'h0002), 32'h220, 1'b0);
        add(mk_r(14, 15, 30), 32'h224, 1'b0);
        run_seq();
    endtask

    task automatic t_reset_in_flight();
        id_instr = mk_r(1, 2, 6); id_pc4 = 32'h300;
        @(negedge clk);
        id_instr = mk_i(6'b100011, 1, 7, 16'h0); id_pc4 = 32'h304;
        @(negedge clk);
        id_instr = BUBBLE; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R10", "wb_reg_write after reset", {31'd0, wb_reg_write}, 32'd0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_single_kinds();
        t_branches();
        t_unknown();
        t_stream();
        t_reset_in_flight();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule